// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits at the write port of a parallel nonvolatile memory controller. It watches every byte-write strobe, each with its address and data byte, and spots the keyed multi-write sequences that host software uses to unlock protected operations. When a sequence completes, it raises a one-cycle command pulse. The commands are: arm sector programming, enter identification mode, leave identification mode, and lock the lower or the upper boot region. Data latching, program timing and the storage array are handled by other blocks. Those blocks consume the pulses and drive the `busy` and `prog_done` inputs.

Every sequence opens with the same two-write key. Write `8'hAA` to command address `15'h5555`, then write `8'h55` to command address `15'h2AAA`. A third write to `15'h5555` then selects the operation by its data byte:

- `8'hA0` arms sector programming.
- `8'h90` enters identification mode.
- `8'hF0` leaves identification mode.
- `8'h80` starts the longer lockout sequence.

The lockout sequence repeats the two-write key, then expects `8'h40` to `15'h5555`. One final write then picks the region, and this final write is compared on the full address.

The decoder steps through seven named states. `ST_IDLE` waits for the first key write. `ST_KEY1` has seen the first key write. `ST_KEY2` has seen both key writes and waits for the selector. `ST_LK_ARM` has seen the lockout selector. `ST_LK_KEY1` has seen the repeated first key write. `ST_LK_KEY2` has seen the repeated second key write. `ST_LK_FINAL` has seen the lockout confirm and waits for the region write.

The transitions are:

- Each matching write advances one state along the chain.
- The selector write in `ST_KEY2` returns to `ST_IDLE` with a command, except `8'h80`, which moves to `ST_LK_ARM`.
- The region write in `ST_LK_FINAL` returns to `ST_IDLE` with a lock command.
- A mismatch in any state returns to `ST_IDLE` and flags a stray write.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset all command pulses, `stray_write` and `prog_armed` are low, and the decoder is in `ST_IDLE`. A lone `8'hA0` write to `15'h5555` then produces only a stray pulse.
- R2: Command addresses are matched on `wr_addr[14:0]` only. Bits 16:15 are ignored for every write except the final lockout write.
- R3: The opening key is `8'hAA` to `15'h5555`, then `8'h55` to `15'h2AAA`. No command can issue without it.
- R4: After the key, `8'hA0` to `15'h5555` pulses `cmd_prog_en` and sets `prog_armed` in the same cycle.
- R5: After the key, `8'h90` to `15'h5555` pulses `cmd_id_enter`, and `8'hF0` to `15'h5555` pulses `cmd_id_exit`.
- R6: The key, then `8'h80`@`5555`, then the key again, then `8'h40`@`5555`, then `8'h00` to full address `17'h00000` pulses `cmd_lock_low`.
- R7: The same seven-write sequence ending with `8'hFF` to full address `17'h1FFFF` pulses `cmd_lock_high`. `8'hFF` to `17'h0FFFF` locks nothing and is a stray write.
- R8: A write that does not match the next expected address and data pair returns the decoder to `ST_IDLE`, pulses `stray_write`, and issues no command.
- R9: A write presented while `busy` is high changes no state and produces no pulse.
- R10: `prog_done` clears `prog_armed`. If a program-arm command lands in the same cycle, the set wins.
- R11: Each output pulse lasts exactly one cycle, follows the accepted write by one clock edge, and at most one pulse is high per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A byte-write strobe is present this cycle |
| wr_addr | input | 17 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| busy | input | 1 | Controller is in a write-cycle period; writes are ignored |
| prog_done | input | 1 | A program cycle has finished; disarms programming |
| cmd_prog_en | output | 1 | One-cycle pulse: sector programming unlocked |
| cmd_id_enter | output | 1 | One-cycle pulse: enter identification mode |
| cmd_id_exit | output | 1 | One-cycle pulse: leave identification mode |
| cmd_lock_low | output | 1 | One-cycle pulse: lock lower boot region |
| cmd_lock_high | output | 1 | One-cycle pulse: lock upper boot region |
| stray_write | output | 1 | One-cycle pulse: write outside a valid sequence (store nothing, start a busy period) |
| prog_armed | output | 1 | Level: sector programming is enabled until `prog_done` |

## Verification
The decoder's state cannot be seen at the ports, so a wrong state shows up only at the next accepted write. A skipped or repeated state turns a correct next write into a stray pulse, or issues a command one write too early. Either shows one clock edge after that write. A busy write that leaks into the state machine shifts every later comparison, so the bench lets the sequence finish after busy drops and checks that the command still fires on the proper write. A reference model compared on every cycle catches these shifts at the first write where the two diverge.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int KEY_AW = 15;
    localparam logic [KEY_AW-1:0] ADDR_KEY_A = 15'h5555;
    localparam logic [KEY_AW-1:0] ADDR_KEY_B = 15'h2AAA;

    localparam logic [7:0] DAT_KEY_A    = 8'hAA;
    localparam logic [7:0] DAT_KEY_B    = 8'h55;
    localparam logic [7:0] DAT_PROG     = 8'hA0;
    localparam logic [7:0] DAT_ID_IN    = 8'h90;
    localparam logic [7:0] DAT_ID_OUT   = 8'hF0;
    localparam logic [7:0] DAT_LK_ARM   = 8'h80;
    localparam logic [7:0] DAT_LK_GO    = 8'h40;
    localparam logic [7:0] DAT_BOOT_LO  = 8'h00;
    localparam logic [7:0] DAT_BOOT_HI  = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_LK_ARM,
        ST_LK_KEY1,
        ST_LK_KEY2,
        ST_LK_FINAL
    } useq_state_e;

    typedef enum logic [3:0] {
        KEY_NONE,
        KEY_FIRST,
        KEY_SECOND,
        KEY_PROG,
        KEY_ID_IN,
        KEY_ID_OUT,
        KEY_LK_ARM,
        KEY_LK_GO,
        KEY_BOOT_LO,
        KEY_BOOT_HI
    } useq_key_e;

    typedef struct packed {
        logic prog;
        logic id_in;
        logic id_out;
        logic boot_lo;
        logic boot_hi;
        logic stray;
    } useq_cmd_t;

endpackage

// File: rtl/useq_key_match.sv
module useq_key_match
    import useq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int CMP_W  = KEY_AW
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output useq_key_e         key_o
);

    localparam logic [ADDR_W-1:0] FULL_LO = '0;
    localparam logic [ADDR_W-1:0] FULL_HI = '1;

    logic [CMP_W-1:0] cmd_addr;
    logic             at_a;
    logic             at_b;

    assign cmd_addr = addr_i[CMP_W-1:0];
    assign at_a     = (cmd_addr == CMP_W'(ADDR_KEY_A));
    assign at_b     = (cmd_addr == CMP_W'(ADDR_KEY_B));

    always_comb begin
        key_o = KEY_NONE;
        if (at_a) begin
            unique case (data_i)
                DATA_W'(DAT_KEY_A):  key_o = KEY_FIRST;
                DATA_W'(DAT_PROG):   key_o = KEY_PROG;
                DATA_W'(DAT_ID_IN):  key_o = KEY_ID_IN;
                DATA_W'(DAT_ID_OUT): key_o = KEY_ID_OUT;
                DATA_W'(DAT_LK_ARM): key_o = KEY_LK_ARM;
                DATA_W'(DAT_LK_GO):  key_o = KEY_LK_GO;
                default:             key_o = KEY_NONE;
            endcase
        end else if (at_b) begin
            if (data_i == DATA_W'(DAT_KEY_B)) key_o = KEY_SECOND;
        end else if (addr_i == FULL_LO) begin
            if (data_i == DATA_W'(DAT_BOOT_LO)) key_o = KEY_BOOT_LO;
        end else if (addr_i == FULL_HI) begin
            if (data_i == DATA_W'(DAT_BOOT_HI)) key_o = KEY_BOOT_HI;
        end
    end

endmodule

// File: rtl/useq_fsm.sv
module useq_fsm
    import useq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept_i,
    input  useq_key_e key_i,
    output logic      prog_set_o,
    output useq_cmd_t cmd_o
);

    useq_state_e state_q, state_d;
    useq_cmd_t   cmd_d, cmd_q;

    always_comb begin
        state_d = state_q;
        cmd_d   = '0;
        if (accept_i) begin
            state_d     = ST_IDLE;
            cmd_d.stray = 1'b1;
            unique case (state_q)
                ST_IDLE: if (key_i == KEY_FIRST) begin
                    state_d = ST_KEY1; cmd_d.stray = 1'b0;
                end
                ST_KEY1: if (key_i == KEY_SECOND) begin
                    state_d = ST_KEY2; cmd_d.stray = 1'b0;
                end
                ST_KEY2: begin
                    cmd_d.stray = 1'b0;
                    unique case (key_i)
                        KEY_PROG:   cmd_d.prog   = 1'b1;
                        KEY_ID_IN:  cmd_d.id_in  = 1'b1;
                        KEY_ID_OUT: cmd_d.id_out = 1'b1;
                        KEY_LK_ARM: state_d      = ST_LK_ARM;
                        default:    cmd_d.stray  = 1'b1;
                    endcase
                end
                ST_LK_ARM: if (key_i == KEY_FIRST) begin
                    state_d = ST_LK_KEY1; cmd_d.stray = 1'b0;
                end
                ST_LK_KEY1: if (key_i == KEY_SECOND) begin
                    state_d = ST_LK_KEY2; cmd_d.stray = 1'b0;
                end
                ST_LK_KEY2: if (key_i == KEY_LK_GO) begin
                    state_d = ST_LK_FINAL; cmd_d.stray = 1'b0;
                end
                ST_LK_FINAL: begin
                    if (key_i == KEY_BOOT_LO) begin
                        cmd_d.boot_lo = 1'b1; cmd_d.stray = 1'b0;
                    end else if (key_i == KEY_BOOT_HI) begin
                        cmd_d.boot_hi = 1'b1; cmd_d.stray = 1'b0;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign prog_set_o = cmd_d.prog;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign cmd_o = cmd_q;

    AST_HOLD_WHEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_i |=> $stable(state_q) && (cmd_q == '0)); // R9
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_q)); // R11
    AST_PROG_FROM_KEY2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q.prog |-> $past(state_q == ST_KEY2)); // R4
    AST_LOCK_FROM_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.boot_lo || cmd_q.boot_hi) |-> $past(state_q == ST_LK_FINAL)); // R6
    AST_STRAY_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q.stray |-> (state_q == ST_IDLE)); // R8

endmodule

// File: rtl/useq_arm.sv
module useq_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic armed_o
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     armed_q <= 1'b0;
        else if (set_i) armed_q <= 1'b1;
        else if (clr_i) armed_q <= 1'b0;
    end

    assign armed_o = armed_q;

    AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> armed_q); // R4
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !armed_q); // R10

endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
    import useq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              prog_done,
    output logic              cmd_prog_en,
    output logic              cmd_id_enter,
    output logic              cmd_id_exit,
    output logic              cmd_lock_low,
    output logic              cmd_lock_high,
    output logic              stray_write,
    output logic              prog_armed
);

    useq_key_e key;
    useq_cmd_t cmd;
    logic      accept;
    logic      prog_set;

    assign accept = wr_valid && !busy;

    useq_key_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(KEY_AW)) u_match (
        .addr_i (wr_addr),
        .data_i (wr_data),
        .key_o  (key)
    );

    useq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .key_i      (key),
        .prog_set_o (prog_set),
        .cmd_o      (cmd)
    );

    useq_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (prog_set),
        .clr_i   (prog_done),
        .armed_o (prog_armed)
    );

    assign cmd_prog_en   = cmd.prog;
    assign cmd_id_enter  = cmd.id_in;
    assign cmd_id_exit   = cmd.id_out;
    assign cmd_lock_low  = cmd.boot_lo;
    assign cmd_lock_high = cmd.boot_hi;
    assign stray_write   = cmd.stray;

    AST_PROG_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_prog_en |=> !cmd_prog_en); // R11
    AST_BUSY_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && busy) |=> !stray_write && !cmd_prog_en); // R9

endmodule

// File: tb/unlock_seq_decoder_bench.sv
module unlock_seq_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy = 1'b0;
    logic        prog_done = 1'b0;
    logic cmd_prog_en, cmd_id_enter, cmd_id_exit, cmd_lock_low, cmd_lock_high;
    logic stray_write, prog_armed;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    unlock_seq_decoder u_unlock_seq_decoder (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .prog_done(prog_done),
        .cmd_prog_en(cmd_prog_en), .cmd_id_enter(cmd_id_enter),
        .cmd_id_exit(cmd_id_exit), .cmd_lock_low(cmd_lock_low),
        .cmd_lock_high(cmd_lock_high), .stray_write(stray_write),
        .prog_armed(prog_armed)
    );

    // behavioural reference model
    int m_st = 0;
    bit e_prog, e_in, e_out, e_lo, e_hi, e_stray, e_armed;

    always @(posedge clk) begin
        int lo;
        bit hit;
        e_prog = 0; e_in = 0; e_out = 0; e_lo = 0; e_hi = 0; e_stray = 0;
        if (!rst_n) begin
            m_st = 0; e_armed = 0;
        end else begin
            if (wr_valid && !busy) begin
                lo = int'(wr_addr) & 32'h7FFF;
                hit = 0;
                if (m_st == 0 && lo == 'h5555 && wr_data == 8'hAA) begin m_st = 1; hit = 1; end
                else if (m_st == 1 && lo == 'h2AAA && wr_data == 8'h55) begin m_st = 2; hit = 1; end
                else if (m_st == 2 && lo == 'h5555) begin
                    if (wr_data == 8'hA0) begin e_prog = 1; m_st = 0; hit = 1; end
                    else if (wr_data == 8'h90) begin e_in = 1; m_st = 0; hit = 1; end
                    else if (wr_data == 8'hF0) begin e_out = 1; m_st = 0; hit = 1; end
                    else if (wr_data == 8'h80) begin m_st = 3; hit = 1; end
                end
                else if (m_st == 3 && lo == 'h5555 && wr_data == 8'hAA) begin m_st = 4; hit = 1; end
                else if (m_st == 4 && lo == 'h2AAA && wr_data == 8'h55) begin m_st = 5; hit = 1; end
                else if (m_st == 5 && lo == 'h5555 && wr_data == 8'h40) begin m_st = 6; hit = 1; end
                else if (m_st == 6) begin
                    if (wr_addr == 17'h00000 && wr_data == 8'h00) begin e_lo = 1; m_st = 0; hit = 1; end
                    else if (wr_addr == 17'h1FFFF && wr_data == 8'hFF) begin e_hi = 1; m_st = 0; hit = 1; end
                end
                if (!hit) begin m_st = 0; e_stray = 1; end
            end
            if (e_prog) e_armed = 1;
            else if (prog_done) e_armed = 0;
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // cycle compare against the model
    always @(negedge clk) begin
        if (!done) begin
            chk("R4",  "cmd_prog_en",   cmd_prog_en,   e_prog);
            chk("R5",  "cmd_id_enter",  cmd_id_enter,  e_in);
            chk("R5",  "cmd_id_exit",   cmd_id_exit,   e_out);
            chk("R6",  "cmd_lock_low",  cmd_lock_low,  e_lo);
            chk("R7",  "cmd_lock_high", cmd_lock_high, e_hi);
            chk("R8",  "stray_write",   stray_write,   e_stray);
            chk("R10", "prog_armed",    prog_armed,    e_armed);
        end
    end

    task automatic wr(logic [16:0] a, logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic key_pair();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
    endtask

    task automatic lock_prefix();
        key_pair();
        wr(17'h05555, 8'h80);
        key_pair();
        wr(17'h05555, 8'h40);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "prog_armed after reset", prog_armed, 1'b0);
        chk("R1", "stray after reset", stray_write, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: lone selector from idle is stray
        wr(17'h05555, 8'hA0);
        chk("R1", "lone A0 stray", stray_write, 1'b1);
        chk("R1", "lone A0 no prog", cmd_prog_en, 1'b0);

        // R3 R4: key then program arm
        key_pair();
        wr(17'h05555, 8'hA0);
        chk("R4", "prog pulse", cmd_prog_en, 1'b1);
        chk("R4", "armed", prog_armed, 1'b1);
        @(negedge clk);
        chk("R11", "prog pulse one cycle", cmd_prog_en, 1'b0);

        // R10: prog_done clears
        prog_done = 1'b1; @(negedge clk); prog_done = 1'b0;
        chk("R10", "armed cleared", prog_armed, 1'b0);

        // R5
        key_pair(); wr(17'h05555, 8'h90);
        chk("R5", "id enter", cmd_id_enter, 1'b1);
        key_pair(); wr(17'h05555, 8'hF0);
        chk("R5", "id exit", cmd_id_exit, 1'b1);

        // R2: upper address bits ignored on command addresses
        wr(17'h15555, 8'hAA); wr(17'h12AAA, 8'h55); wr(17'h0D555, 8'h90);
        chk("R2", "aliased id enter", cmd_id_enter, 1'b1);

        // R6 R7
        lock_prefix(); wr(17'h00000, 8'h00);
        chk("R6", "lock low", cmd_lock_low, 1'b1);
        lock_prefix(); wr(17'h1FFFF, 8'hFF);
        chk("R7", "lock high", cmd_lock_high, 1'b1);
        lock_prefix(); wr(17'h0FFFF, 8'hFF);
        chk("R7", "partial addr no lock", cmd_lock_high, 1'b0);
        chk("R7", "partial addr stray", stray_write, 1'b1);

        // R8: mismatch returns to idle
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h56);
        chk("R8", "bad key stray", stray_write, 1'b1);
        wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
        chk("R8", "no prog after miss", cmd_prog_en, 1'b0);

        // R9: busy writes ignored
        wr(17'h05555, 8'hAA);
        busy = 1'b1;
        wr(17'h00123, 8'h12);
        chk("R9", "busy write no stray", stray_write, 1'b0);
        busy = 1'b0;
        wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
        chk("R9", "sequence survives busy", cmd_prog_en, 1'b1);

        // R10: set wins over same-cycle clear
        prog_done = 1'b1; @(negedge clk); prog_done = 1'b0;
        key_pair();
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 17'h05555; wr_data = 8'hA0; prog_done = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; prog_done = 1'b0;
        chk("R10", "set wins", prog_armed, 1'b1);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule